// File: doc/BRIEF.md
# Byte-Lane Static Memory Access Decoder

This block is a clocked model of the control path inside a 16-bit-wide static memory. On every rising edge of the system clock it samples two chip selects of opposite polarity, a write strobe, an output strobe, two byte-lane selects and a width-mode pin. From these it works out whether the cycle is idle, a read, a write or a cycle that drives nothing. The data bus is split into an input vector, an output vector and a per-bit output-enable vector, so an I/O ring or a testbench can rebuild the bidirectional pins.

In 16-bit mode each byte lane is steered by its own select. In 8-bit mode the lane selects have no effect. Only bits 7:0 carry data, and bit 15 of the input bus becomes the lowest address bit, which picks the low or high byte of the addressed word. The storage is a small array whose depth is a parameter. Address bits above that depth are not decoded.

Top module: `bytelane_sram_ctrl`

## Requirements
- R1: The part is selected only when `sel_n` is 0 and `sel_hi` is 1. In any other sampled cycle nothing is written, and `dq_oe` is all zero after that edge.
- R2: In 16-bit mode (`word_mode`=1), a selected cycle with both `lane_lo_n` and `lane_hi_n` at 1 is idle: nothing is written and `dq_oe` is all zero.
- R3: A selected cycle with `wr_n`=1 and `oe_n`=0 is a read. After the sampling edge, bits 7:0 are driven only if `lane_lo_n` was 0 and bits 15:8 only if `lane_hi_n` was 0. Each driven lane carries the stored byte of word `addr`.
- R4: A selected cycle with `wr_n`=0 is a write whatever `oe_n` is. In 16-bit mode, bits 7:0 of `dq_in` go to the low byte when `lane_lo_n`=0, and bits 15:8 go to the high byte when `lane_hi_n`=0. `dq_oe` is all zero after a write cycle.
- R5: A selected cycle with `wr_n`=1 and `oe_n`=1 drives nothing: `dq_oe` is all zero after it.
- R6: In 8-bit mode (`word_mode`=0), `lane_lo_n` and `lane_hi_n` are ignored. A read drives only bits 7:0 (`dq_oe`=16'h00FF), and bits 15:8 stay undriven. Bit 15 of `dq_in` is the extra low address bit.
- R7: In 8-bit mode, an extra address bit of 0 selects the low byte (bits 7:0) of word `addr` and a 1 selects the high byte (bits 15:8). Write data comes from `dq_in[7:0]`, and read data appears on `dq_out[7:0]`.
- R8: A write stores data only in a sampled cycle where select, write strobe and at least one lane are all active together. Cycles in which only some of these conditions hold leave the memory unchanged.
- R9: Only the low `DEPTH_W` bits of `addr` are decoded (default 10, so 1024 words). Addresses that differ only above bit `DEPTH_W`-1 reach the same word.
- R10: Data written in one cycle is returned by a read of the same word and lane in the very next cycle.
- R11: After a synchronous reset (`rst_n`=0 at a rising edge), `dq_oe` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output strobe |
| lane_lo_n | input | 1 | Active-low select for data bits 7:0 (16-bit mode) |
| lane_hi_n | input | 1 | Active-low select for data bits 15:8 (16-bit mode) |
| word_mode | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| addr | input | 20 | Word address |
| dq_in | input | 16 | Data bus as seen from the pins; bit 15 is the extra address bit in 8-bit mode |
| dq_out | output | 16 | Data driven toward the pins |
| dq_oe | output | 16 | Per-bit output enable for `dq_out` |

## Verification
Every result is due one clock after the edge that samples the pins. A read sampled at edge k shows its data and enables after edge k. A write sampled at edge k changes the array at that edge, so a read sampled at edge k+1 returns the new data. The bench changes pins just after a falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Each check therefore lands on the cycle its result is due, with no slack that could hide a lost or extra register stage.

// File: rtl/sram_dec_pkg.sv
// Shared types for the byte-lane memory access decoder.
package sram_dec_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_HIZ   = 2'd3
    } op_t;
endpackage

// File: rtl/sram_op_decode.sv
// Decodes the sampled control pins into one operation, a lane mask and
// lane-aligned write data. Assumes the pins are already synchronous to clk.
module sram_op_decode
    import sram_dec_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] dq_in,
    output op_t               op,
    output logic [LANES-1:0]  lane_en,
    output logic [LANES-1:0]  wr_lane,
    output logic              hi_sel,
    output logic [DATA_W-1:0] wdata
);
    logic selected;

    // Lane selection: per-lane pins in word mode, extra address bit in byte mode.
    always_comb begin
        selected = !sel_n && sel_hi;
        hi_sel   = dq_in[DATA_W-1];
        lane_en  = '0;
        if (word_mode) begin
            lane_en[0]       = !lane_lo_n;
            lane_en[LANES-1] = !lane_hi_n;
        end else begin
            lane_en[0]       = !hi_sel;
            lane_en[LANES-1] = hi_sel;
        end
    end

    // Operation priority: deselect/no-lane idle, then write, read, float.
    always_comb begin
        if (!selected || lane_en == '0)
            op = OP_IDLE;
        else if (!wr_n)
            op = OP_WRITE;
        else if (!oe_n)
            op = OP_READ;
        else
            op = OP_HIZ;
        wr_lane = (op == OP_WRITE) ? lane_en : '0;
    end

    // Write data alignment: byte mode replicates the low byte onto every lane.
    always_comb begin
        for (int g = 0; g < LANES; g++)
            wdata[g*8 +: 8] = word_mode ? dq_in[g*8 +: 8] : dq_in[7:0];
    end

    // R6
    byte_write_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !sel_n && sel_hi && !word_mode) |-> ($countones(wr_lane) == 1));

    // R1
    deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel_hi) |-> (wr_lane == '0));
endmodule

// File: rtl/sram_lane_array.sv
// Storage split into independent 8-bit lanes, each with its own write
// enable. Read data is registered; a write at edge k is visible at k+1.
module sram_lane_array #(
    parameter int DATA_W  = 16,
    parameter int DEPTH_W = 10,
    localparam int LANES  = DATA_W / 8,
    localparam int DEPTH  = 1 << DEPTH_W
) (
    input  logic               clk,
    input  logic [DEPTH_W-1:0] idx,
    input  logic [LANES-1:0]   we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [DEPTH];

        // Per-lane write and registered read of the addressed word.
        always_ff @(posedge clk) begin
            if (we[g])
                mem[idx] <= wdata[g*8 +: 8];
            rdata[g*8 +: 8] <= mem[idx];
        end
    end
endmodule

// File: rtl/sram_bus_drive.sv
// Forms the output data and per-bit enables from the registered operation.
// Assumes rdata belongs to the same sampled cycle as op_q.
module sram_bus_drive
    import sram_dec_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  op_t               op_q,
    input  logic              byte_q,
    input  logic              hi_sel_q,
    input  logic [LANES-1:0]  lane_q,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    // Drive only during reads; byte mode narrows the bus to the low lane.
    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (op_q == OP_READ) begin
            if (byte_q) begin
                dq_out[7:0] = hi_sel_q ? rdata[DATA_W-1 -: 8] : rdata[7:0];
                dq_oe[7:0]  = '1;
            end else begin
                dq_out = rdata;
                for (int g = 0; g < LANES; g++)
                    dq_oe[g*8 +: 8] = {8{lane_q[g]}};
            end
        end
    end
endmodule

// File: rtl/bytelane_sram_ctrl.sv
// Top of the byte-lane memory access decoder. Samples all pins on clk,
// writes the array at the sampling edge and presents read results one
// clock later. Assumes 8-bit lanes and DATA_W = 16.
module bytelane_sram_ctrl
    import sram_dec_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DEPTH_W = 10,
    parameter int DATA_W  = 16,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    op_t               op, op_q;
    logic [LANES-1:0]  lane_en, wr_lane, lane_q;
    logic              hi_sel, hi_sel_q, byte_q;
    logic [DATA_W-1:0] wdata, rdata;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:DEPTH_W];

    sram_op_decode #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi),
        .wr_n(wr_n), .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
        .word_mode(word_mode), .dq_in(dq_in), .op(op), .lane_en(lane_en),
        .wr_lane(wr_lane), .hi_sel(hi_sel), .wdata(wdata)
    );

    sram_lane_array #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_arr (
        .clk(clk), .idx(addr[DEPTH_W-1:0]), .we(wr_lane),
        .wdata(wdata), .rdata(rdata)
    );

    // Hold the decoded operation for the cycle in which its data appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            lane_q   <= '0;
            byte_q   <= 1'b0;
            hi_sel_q <= 1'b0;
        end else begin
            op_q     <= op;
            lane_q   <= lane_en;
            byte_q   <= !word_mode;
            hi_sel_q <= hi_sel;
        end
    end

    sram_bus_drive #(.DATA_W(DATA_W)) u_drv (
        .op_q(op_q), .byte_q(byte_q), .hi_sel_q(hi_sel_q), .lane_q(lane_q),
        .rdata(rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // R1
    deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || !sel_hi) |=> (dq_oe == '0));

    // R2
    no_lane_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && lane_lo_n && lane_hi_n) |=> (dq_oe == '0));

    // R4
    write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n) |=> (dq_oe == '0));

    // R5
    oe_off_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && oe_n) |=> (dq_oe == '0));

    // R6
    byte_upper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode) |=> (dq_oe[DATA_W-1:8] == '0));

    // R3
    read_low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && sel_hi && wr_n && !oe_n && word_mode && !lane_lo_n)
        |=> (dq_oe[7:0] == 8'hFF));
endmodule

// File: tb/sim_bytelane_sram_ctrl.sv
module sim_bytelane_sram_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic        lane_lo_n = 1'b1, lane_hi_n = 1'b1, word_mode = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytelane_sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi),
        .wr_n(wr_n), .oe_n(oe_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
        .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one sampled cycle, then leave pins in a quiet state.
    task automatic cyc(input logic s_n, input logic s_hi, input logic w_n, input logic o_n,
                       input logic lo_n, input logic hi_n, input logic wm,
                       input logic [19:0] a, input logic [15:0] d);
        sel_n = s_n; sel_hi = s_hi; wr_n = w_n; oe_n = o_n;
        lane_lo_n = lo_n; lane_hi_n = hi_n; word_mode = wm; addr = a; dq_in = d;
        tick();
        sel_n = 1'b1; sel_hi = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
        lane_lo_n = 1'b1; lane_hi_n = 1'b1; word_mode = 1'b1;
    endtask

    task automatic wr_word(input logic [19:0] a, input logic [15:0] d, input logic lo_n, input logic hi_n);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, lo_n, hi_n, 1'b1, a, d);
    endtask

    task automatic rd_word(input logic [19:0] a, input logic lo_n, input logic hi_n);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, lo_n, hi_n, 1'b1, a, 16'h0000);
    endtask

    task automatic t_reset();
        chk("R11 reset oe", dq_oe, 16'h0000);
    endtask

    task automatic t_word_rw();
        wr_word(20'd5, 16'h1234, 1'b0, 1'b0);
        chk("R4 write floats bus", dq_oe, 16'h0000);
        rd_word(20'd5, 1'b0, 1'b0);
        chk("R10 next-cycle read data", dq_out, 16'h1234);
        chk("R3 full read oe", dq_oe, 16'hFFFF);
    endtask

    task automatic t_lanes();
        wr_word(20'd5, 16'hFFAB, 1'b0, 1'b1);
        rd_word(20'd5, 1'b0, 1'b0);
        chk("R4 lower-only write", dq_out, 16'h12AB);
        wr_word(20'd5, 16'hCD00, 1'b1, 1'b0);
        rd_word(20'd5, 1'b0, 1'b0);
        chk("R4 upper-only write", dq_out, 16'hCDAB);
        rd_word(20'd5, 1'b0, 1'b1);
        chk("R3 lower lane oe", dq_oe, 16'h00FF);
        chk("R3 lower lane data", dq_out & 16'h00FF, 16'h00AB);
        rd_word(20'd5, 1'b1, 1'b0);
        chk("R3 upper lane oe", dq_oe, 16'hFF00);
        chk("R3 upper lane data", dq_out & 16'hFF00, 16'hCD00);
    endtask

    task automatic t_deselect();
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'd5, 16'h0);
        chk("R1 sel_n high read floats", dq_oe, 16'h0000);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 20'd5, 16'h0);
        chk("R1 sel_hi low read floats", dq_oe, 16'h0000);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'd5, 16'h0000);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'd5, 16'h0000);
        rd_word(20'd5, 1'b0, 1'b0);
        chk("R1 deselected writes ignored", dq_out, 16'hCDAB);
    endtask

    task automatic t_no_lane();
        rd_word(20'd5, 1'b1, 1'b1);
        chk("R2 no-lane read floats", dq_oe, 16'h0000);
        wr_word(20'd5, 16'h5555, 1'b1, 1'b1);
        rd_word(20'd5, 1'b0, 1'b0);
        chk("R2 no-lane write ignored", dq_out, 16'hCDAB);
    endtask

    task automatic t_hiz();
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20'd5, 16'h0);
        chk("R5 output disable", dq_oe, 16'h0000);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 20'd6, 16'h0F0F);
        chk("R4 write with oe_n low floats", dq_oe, 16'h0000);
        rd_word(20'd6, 1'b0, 1'b0);
        chk("R4 write ignores oe_n", dq_out, 16'h0F0F);
    endtask

    task automatic t_byte();
        wr_word(20'd9, 16'h0000, 1'b0, 1'b0);
        // lane selects held high: must be ignored in byte mode
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'd9, 16'h7F11);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20'd9, 16'h8022);
        rd_word(20'd9, 1'b0, 1'b0);
        chk("R7 byte writes land in lanes", dq_out, 16'h2211);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 20'd9, 16'h8000);
        chk("R6 byte read oe", dq_oe, 16'h00FF);
        chk("R7 byte read upper", dq_out & 16'h00FF, 16'h0022);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 20'd9, 16'h0000);
        chk("R7 byte read lower", dq_out & 16'h00FF, 16'h0011);
        chk("R6 byte read upper bits float", dq_oe & 16'hFF00, 16'h0000);
    endtask

    task automatic t_overlap();
        // R8: strobe first, select later, data changes after strobe rises
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'd12, 16'hAAAA);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 20'd12, 16'h3C3C);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20'd12, 16'h9999);
        rd_word(20'd12, 1'b0, 1'b0);
        chk("R8 only overlap cycle writes", dq_out, 16'h3C3C);
    endtask

    task automatic t_alias();
        wr_word(20'd3, 16'hBEEF, 1'b0, 1'b0);
        rd_word(20'd3 + 20'd1024, 1'b0, 1'b0);
        chk("R9 upper address bits ignored", dq_out, 16'hBEEF);
        wr_word(20'h80003, 16'h4321, 1'b0, 1'b0);
        rd_word(20'd3, 1'b0, 1'b0);
        chk("R9 aliased write", dq_out, 16'h4321);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_rw();
        t_lanes();
        t_deselect();
        t_no_lane();
        t_hiz();
        t_byte();
        t_overlap();
        t_alias();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule